// File: doc/BRIEF.md
# Dual User/System Stack Unit

This block owns the stack pointers of a processor that keeps one stack for user code and a separate one for privileged code. A client hands it a push or a pop over a valid/ready command handshake. The block turns each command into one access on a single-port memory request interface. It then returns a one-cycle response. For a pop, the response carries the word read back. A pop from an empty stack is refused and reported as an underflow. There is no overflow check.

Two pointers are banked inside the block, one per privilege level. The privilege input, sampled when a command is accepted, picks which pointer the command uses. The user pointer starts at 999 and the system pointer at 1999. Both stacks grow toward lower addresses. A push moves the pointer down first and then writes at the new value. A pop reads at the current value and then moves the pointer up. A stack is empty when its pointer equals its base.

The controller is a four-state machine:
- IDLE waits for a command. From IDLE, a push goes to PUSH_WR. A pop of a non-empty stack goes to POP_RD. A pop of an empty stack goes straight to RESP.
- PUSH_WR and POP_RD hold the memory request until it is acknowledged, then go to RESP.
- RESP drives the response for one cycle and returns to IDLE.

Top module: `dual_stack_unit`

## Requirements
- R1: After reset, the user pointer is 999 and the system pointer is 1999. cmd_ready is 1, mem_req is 0 and rsp_valid is 0.
- R2: An accepted push (cmd_op=0) first lowers the selected pointer by one. It then requests a write (mem_we=1) at the lowered address, with mem_wdata equal to the command's data.
- R3: An accepted pop (cmd_op=1) of a non-empty stack requests a read (mem_we=0) at the current pointer. On mem_ack it raises the pointer by one, and rsp_data returns the mem_rdata seen with that acknowledge.
- R4: mode_sys=0 selects the user stack and mode_sys=1 the system stack. The mode is sampled in the accepting cycle only. The other bank's pointer is unaffected.
- R5: A pop when the selected pointer equals its base gives a response with rsp_underflow=1 in the cycle after acceptance. It issues no memory request and leaves the pointer unchanged.
- R6: cmd_ready is 1 only in IDLE. It is 0 from the cycle after acceptance until the response cycle has passed, which covers the whole time a memory access is outstanding.
- R7: Once raised, mem_req stays 1, with mem_addr, mem_we and mem_wdata unchanged, until a cycle in which mem_ack is 1. It falls in the next cycle.
- R8: rsp_valid is a single-cycle pulse in the cycle after mem_ack, or after acceptance for an underflow. A push response has rsp_underflow=0 and rsp_data=0.
- R9: Pushes are never refused and never flagged. The unit accepts a push at any depth, and the deep entries pop back in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sys | input | 1 | Privilege: 0 user stack, 1 system stack |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_op | input | 1 | 0 push, 1 pop |
| cmd_data | input | DATA_W | Word to push |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | DATA_W | Popped word (0 for push or underflow) |
| rsp_underflow | output | 1 | Pop refused, stack empty |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access done this cycle (read data valid) |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |

## Verification
The memory request is due in the first cycle after acceptance. The response follows one cycle after the acknowledge, and cmd_ready returns one cycle after that. An underflow response is due in the first cycle after acceptance, with no request at all.

The bench drives every input on the falling edge. It samples each output on the next falling edge, exactly at the cycle its reference model predicts. It varies the acknowledge delay from zero to several cycles and checks every wait cycle for a held, unchanged request. It also flips mode_sys right after acceptance, to show that only the sampled mode counts.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUSH_WR = 2'd1,
        ST_POP_RD  = 2'd2,
        ST_RESP    = 2'd3
    } dsu_state_t;

    localparam logic OP_PUSH = 1'b0;
    localparam logic OP_POP  = 1'b1;

    localparam logic BANK_USER = 1'b0;
    localparam logic BANK_SYS  = 1'b1;

endpackage

// File: rtl/dsu_ptr_bank.sv
module dsu_ptr_bank #(
    parameter int ADDR_W    = 11,
    parameter int USER_BASE = 999,
    parameter int SYS_BASE  = 1999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              dec_en,
    input  logic              inc_en,
    output logic [ADDR_W-1:0] sp,
    output logic              empty
);
    localparam int NBANK = 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] sp_r   [NBANK];
    logic [ADDR_W-1:0] base_w [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE =
            (b == 0) ? ADDR_W'(USER_BASE) : ADDR_W'(SYS_BASE);

        assign base_w[b] = BASE;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sp_r[b] <= BASE;
            end else if (sel == 1'(b)) begin
                if (dec_en) begin
                    sp_r[b] <= sp_r[b] - STEP;
                end else if (inc_en) begin
                    sp_r[b] <= sp_r[b] + STEP;
                end
            end
        end
    end

    assign sp    = sp_r[sel];
    assign empty = (sp_r[sel] == base_w[sel]);

endmodule

// File: rtl/dsu_ctrl.sv
module dsu_ctrl
    import dsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sys,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [ADDR_W-1:0] sp,
    input  logic              empty,
    output logic              bank_sel,
    output logic              dec_en,
    output logic              inc_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_underflow
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    dsu_state_t        state, nxt;
    logic              fire;
    logic              cap_bank;
    logic              cap_pop;
    logic              cap_uf;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_wdata;
    logic [DATA_W-1:0] rd_q;

    assign fire = cmd_valid && (state == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // command capture and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_bank  <= BANK_USER;
            cap_pop   <= 1'b0;
            cap_uf    <= 1'b0;
            cap_addr  <= '0;
            cap_wdata <= '0;
            rd_q      <= '0;
        end else begin
            if (fire) begin
                cap_bank  <= mode_sys;
                cap_pop   <= (cmd_op == OP_POP);
                cap_uf    <= (cmd_op == OP_POP) && empty;
                cap_addr  <= (cmd_op == OP_PUSH) ? (sp - STEP) : sp;
                cap_wdata <= cmd_data;
                rd_q      <= '0;
            end else if (state == ST_POP_RD && mem_ack) begin
                rd_q <= mem_rdata;
            end
        end
    end

    // next state and outputs
    always_comb begin
        nxt           = state;
        cmd_ready     = 1'b0;
        bank_sel      = cap_bank;
        dec_en        = 1'b0;
        inc_en        = 1'b0;
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = cap_addr;
        mem_wdata     = cap_wdata;
        rsp_valid     = 1'b0;
        rsp_data      = '0;
        rsp_underflow = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                bank_sel  = mode_sys;
                if (cmd_valid) begin
                    if (cmd_op == OP_PUSH) begin
                        dec_en = 1'b1;
                        nxt    = ST_PUSH_WR;
                    end else if (empty) begin
                        nxt = ST_RESP;
                    end else begin
                        nxt = ST_POP_RD;
                    end
                end
            end
            ST_PUSH_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    nxt = ST_RESP;
                end
            end
            ST_POP_RD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    inc_en = 1'b1;
                    nxt    = ST_RESP;
                end
            end
            ST_RESP: begin
                rsp_valid     = 1'b1;
                rsp_underflow = cap_uf;
                rsp_data      = (cap_pop && !cap_uf) ? rd_q : '0;
                nxt           = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/dual_stack_unit.sv
module dual_stack_unit #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 11,
    parameter int USER_BASE = 999,
    parameter int SYS_BASE  = 1999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sys,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_underflow,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [ADDR_W-1:0] sp;
    logic              empty;
    logic              bank_sel;
    logic              dec_en;
    logic              inc_en;

    dsu_ptr_bank #(
        .ADDR_W   (ADDR_W),
        .USER_BASE(USER_BASE),
        .SYS_BASE (SYS_BASE)
    ) ptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bank_sel),
        .dec_en(dec_en),
        .inc_en(inc_en),
        .sp    (sp),
        .empty (empty)
    );

    dsu_ctrl #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sys     (mode_sys),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_op       (cmd_op),
        .cmd_data     (cmd_data),
        .sp           (sp),
        .empty        (empty),
        .bank_sel     (bank_sel),
        .dec_en       (dec_en),
        .inc_en       (inc_en),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_underflow(rsp_underflow)
    );

endmodule

// File: rtl/dsu_chk.sv
module dsu_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_underflow,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    // R6
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cmd_ready);

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

    // R7
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);

    // R5
    uf_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_underflow |-> !mem_req && !$past(mem_req));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && cmd_ready);

    // R8
    push_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(mem_req && mem_we) |-> !rsp_underflow && rsp_data == '0);

endmodule

bind dual_stack_unit dsu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_underflow(rsp_underflow),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack)
);

// File: tb/dual_stack_unit_tb_top.sv
`timescale 1ns/1ps
module dual_stack_unit_tb_top;
    localparam int DW = 32;
    localparam int AW = 11;
    localparam int UBASE = 999;
    localparam int SBASE = 1999;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_sys = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_op = 1'b0;
    logic [DW-1:0] cmd_data = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_underflow;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    // reference model state
    int            usr_sp = UBASE;
    int            sys_sp = SBASE;
    logic [DW-1:0] usr_q[$];
    logic [DW-1:0] sys_q[$];
    logic [DW-1:0] mem_m[int];

    always #10 clk = ~clk;

    dual_stack_unit #(.DATA_W(DW), .ADDR_W(AW), .USER_BASE(UBASE), .SYS_BASE(SBASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sys(mode_sys),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_underflow(rsp_underflow),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // one command, checked cycle by cycle against the model
    task automatic do_cmd(input bit pop, input bit sys, input logic [DW-1:0] d, input int dly);
        int            sp;
        int            base;
        bit            uf;
        int            exp_addr;
        logic [DW-1:0] exp_data;
        logic [AW-1:0] held_addr;
        sp   = sys ? sys_sp : usr_sp;
        base = sys ? SBASE : UBASE;
        uf   = pop && (sp == base);
        exp_addr = 0;
        exp_data = '0;
        if (!pop) begin
            sp = sp - 1;
            exp_addr = sp;
            if (sys) sys_q.push_back(d); else usr_q.push_back(d);
        end else if (!uf) begin
            exp_addr = sp;
            exp_data = sys ? sys_q.pop_back() : usr_q.pop_back();
            sp = sp + 1;
        end
        if (sys) sys_sp = sp; else usr_sp = sp;

        @(negedge clk);
        chk(cmd_ready == 1'b1, "R6", "cmd_ready idle", longint'(cmd_ready), 1);
        chk(rsp_valid == 1'b0, "R8", "rsp_valid idle", longint'(rsp_valid), 0);
        cmd_valid = 1'b1;
        cmd_op    = pop;
        cmd_data  = d;
        mode_sys  = sys;
        @(negedge clk);
        cmd_valid = 1'b0;
        mode_sys  = ~sys;          // R4: only the accepting cycle counts
        cmd_data  = ~d;
        chk(cmd_ready == 1'b0, "R6", "cmd_ready busy", longint'(cmd_ready), 0);
        if (uf) begin
            chk(rsp_valid == 1'b1, "R5", "uf rsp_valid", longint'(rsp_valid), 1);
            chk(rsp_underflow == 1'b1, "R5", "rsp_underflow", longint'(rsp_underflow), 1);
            chk(mem_req == 1'b0, "R5", "uf mem_req", longint'(mem_req), 0);
        end else begin
            chk(mem_req == 1'b1, pop ? "R3" : "R2", "mem_req", longint'(mem_req), 1);
            chk(mem_we == !pop, pop ? "R3" : "R2", "mem_we", longint'(mem_we), longint'(!pop));
            chk(int'(mem_addr) == exp_addr, sys ? "R4" : (pop ? "R3" : "R2"), "mem_addr",
                longint'(mem_addr), longint'(exp_addr));
            if (!pop) chk(mem_wdata == d, "R2", "mem_wdata", longint'(mem_wdata), longint'(d));
            held_addr = mem_addr;
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                chk(mem_req == 1'b1 && mem_addr == held_addr && rsp_valid == 1'b0, "R7",
                    "request held", longint'(mem_addr), longint'(held_addr));
            end
            if (pop) begin
                mem_rdata = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 32'hDEAD_0000;
            end else begin
                mem_m[int'(mem_addr)] = mem_wdata;
                mem_rdata = 32'h5A5A_5A5A;
            end
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack   = 1'b0;
            mem_rdata = '0;
            chk(mem_req == 1'b0, "R7", "mem_req dropped", longint'(mem_req), 0);
            chk(rsp_valid == 1'b1, "R8", "rsp_valid", longint'(rsp_valid), 1);
            chk(rsp_underflow == 1'b0, "R8", "no underflow", longint'(rsp_underflow), 0);
            chk(rsp_data == exp_data, pop ? "R3" : "R8", "rsp_data",
                longint'(rsp_data), longint'(exp_data));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready", longint'(cmd_ready), 1);
        chk(mem_req == 1'b0, "R1", "mem_req", longint'(mem_req), 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", longint'(rsp_valid), 0);

        // R1 R5: both stacks start empty at their bases
        do_cmd(1'b1, 1'b0, '0, 0);
        do_cmd(1'b1, 1'b1, '0, 0);

        // R2 pushes on the user stack, varied acknowledge delay
        do_cmd(1'b0, 1'b0, 32'h1111_0001, 0);
        do_cmd(1'b0, 1'b0, 32'h1111_0002, 1);
        do_cmd(1'b0, 1'b0, 32'h1111_0003, 3);

        // R4 system stack, other bank untouched
        do_cmd(1'b0, 1'b1, 32'h2222_0001, 2);
        do_cmd(1'b0, 1'b1, 32'h2222_0002, 0);

        // R3 interleaved pops
        do_cmd(1'b1, 1'b0, '0, 1);
        do_cmd(1'b1, 1'b1, '0, 0);
        do_cmd(1'b1, 1'b0, '0, 2);
        do_cmd(1'b1, 1'b0, '0, 0);
        // R5 empty again, then a push shows the pointer stayed at base
        do_cmd(1'b1, 1'b0, '0, 0);
        do_cmd(1'b0, 1'b0, 32'h3333_0001, 0);
        do_cmd(1'b1, 1'b0, '0, 0);

        do_cmd(1'b1, 1'b1, '0, 1);
        do_cmd(1'b1, 1'b1, '0, 0);

        // R9 deep run on the system stack, never refused
        for (int k = 0; k < 40; k++) do_cmd(1'b0, 1'b1, 32'h4000_0000 + k, k % 3);
        for (int k = 0; k < 40; k++) do_cmd(1'b1, 1'b1, '0, (k + 1) % 3);
        do_cmd(1'b1, 1'b1, '0, 0);

        @(negedge clk);
        chk(cmd_ready == 1'b1, "R6", "final cmd_ready", longint'(cmd_ready), 1);
        summary();
    end

endmodule